// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block takes one asynchronous serial line and turns frames on it into bytes. A frame is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then a high stop bit. The block uses a 16x oversampling tick from an external baud divider. It finds the start bit from the falling edge and then takes each following bit near the middle of its bit period, using a majority vote over three consecutive tick samples.

When a frame ends, the received data goes into a single holding buffer. Frame-error and parity-error status are captured with the data. A receive-complete flag sets at the same time. Data bits above the configured width read as zero. A read strobe clears the flag. If a second frame ends before the buffer is read, the buffer keeps the older data and an overrun bit sets. The receiver samples only the first stop bit. It is ready for a new start bit straight after that sample, so a second stop bit from the sender needs no configuration.

Top module: `async_frame_rx`

## Requirements
- R1: While `rx_en` is low the receiver stays idle, whatever the line does. A frame sent while `rx_en` is low never sets `rx_done`.
- R2: A falling edge on the line starts a frame only if the majority of the three tick samples 7, 8 and 9 ticks after detection is low. A low pulse shorter than that returns the receiver to idle and produces no frame. A valid frame that follows is then received correctly.
- R3: `cfg_width` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits arrive least significant bit first, and bit i of `rd_data` is data bit i.
- R4: For widths below 8, the bits of `rd_data` at and above the configured width read as zero.
- R5: When `cfg_par_en` is high, one parity bit follows the data. `cfg_par_odd` = 0 means even parity and 1 means odd parity. `parity_err` is high when the XOR of the data bits and the parity bit differs from `cfg_par_odd`. When `cfg_par_en` is low, `parity_err` is always 0.
- R6: `frame_err` is 1 when the first stop bit samples low, and 0 when it samples high.
- R7: Only the first stop bit is sampled. A start bit that begins right after a one-stop-bit frame is received. A frame followed by an extra high stop bit is received the same way.
- R8: `rx_done` sets when the first stop bit has been sampled, and a one-cycle `rd_strobe` clears it. While `rx_done` is high and no read occurs, `rd_data`, `frame_err` and `parity_err` hold their values.
- R9: If a frame ends while `rx_done` is high and `rd_strobe` is low, `overrun` sets and the buffer keeps the older frame. `rd_strobe` clears `overrun`.
- R10: After reset, `rx_done`, `overrun`, `frame_err`, `parity_err` and `rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial input; high when idle |
| os_tick | input | 1 | One-cycle pulse, 16 per bit period |
| rx_en | input | 1 | Receive enable |
| cfg_width | input | 2 | Data width code: 0 to 3 gives 5 to 8 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 for odd parity, 0 for even |
| rd_strobe | input | 1 | Read pulse; clears `rx_done` and `overrun` |
| rd_data | output | 8 | Received data, upper bits zero-filled |
| rx_done | output | 1 | Receive buffer holds unread data |
| frame_err | output | 1 | Stop bit of the buffered frame sampled low |
| parity_err | output | 1 | Parity of the buffered frame was wrong |
| overrun | output | 1 | A frame was lost while the buffer was full |

## Verification
The checker assumes that `cfg_width` does not change while `rx_done` is high. It also assumes that `os_tick` is never high for two clocks in a row. The stimulus holds the format for the whole sweep of each configuration, and it reads each frame before it changes the format. The stimulus raises the tick on every second clock, so one bit lasts exactly 32 clocks and every bit edge falls at the same tick phase. The stimulus never asserts `rd_strobe` in the cycle in which a frame completes. It reads only after the stop-bit period has ended, or well inside the next frame's start bit.

// File: rtl/async_frame_rx.sv
module async_frame_rx #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic       os_tick,
  input  logic       rx_en,
  input  logic [1:0] cfg_width,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       rd_strobe,
  output logic [7:0] rd_data,
  output logic       rx_done,
  output logic       frame_err,
  output logic       parity_err,
  output logic       overrun
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID = CW'(OSR/2 + 1);

  typedef enum logic [2:0] {IDLE, START, DATA, PAR, STOP} st_t;
  st_t st;

  logic [1:0]    sync;
  logic [1:0]    hist;
  logic [CW-1:0] cnt;
  logic [2:0]    idx;
  logic [7:0]    shreg;
  logic          dpar, pbit;

  wire rxs  = sync[1];
  wire maj  = (hist[1] & hist[0]) | (hist[1] & rxs) | (hist[0] & rxs);
  wire at_mid = os_tick && (cnt == MID);
  wire last_bit = (idx == {1'b0, cfg_width} + 3'd4);
  wire done_now = at_mid && (st == STOP);
  wire [7:0] aligned = shreg >> (2'd3 - cfg_width);
  wire perr_now = cfg_par_en && ((dpar ^ pbit) != cfg_par_odd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rx_line};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; hist <= 2'b11; idx <= '0;
      shreg <= '0; dpar <= 1'b0; pbit <= 1'b0;
    end else if (!rx_en) begin
      st <= IDLE;
    end else if (os_tick) begin
      if (st == IDLE) begin
        if (!rxs) begin
          st <= START; cnt <= CW'(1); hist <= 2'b00;
        end
      end else begin
        hist <= {hist[0], rxs};
        cnt  <= cnt + 1'b1;
        if (cnt == MID) begin
          unique case (st)
            START: if (maj) st <= IDLE;
                   else begin st <= DATA; idx <= '0; dpar <= 1'b0; end
            DATA: begin
              shreg <= {maj, shreg[7:1]};
              dpar  <= dpar ^ maj;
              idx   <= idx + 1'b1;
              if (last_bit) st <= cfg_par_en ? PAR : STOP;
            end
            PAR:  begin pbit <= maj; st <= STOP; end
            default: st <= IDLE;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0; rx_done <= 1'b0; frame_err <= 1'b0;
      parity_err <= 1'b0; overrun <= 1'b0;
    end else begin
      if (rd_strobe) begin
        rx_done <= 1'b0;
        overrun <= 1'b0;
      end
      if (done_now) begin
        if (rx_done && !rd_strobe) begin
          overrun <= 1'b1;
        end else begin
          rd_data    <= aligned;
          frame_err  <= ~maj;
          parity_err <= perr_now;
          rx_done    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/async_frame_rx_chk.sv
module async_frame_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic [1:0] cfg_width,
  input logic       rd_strobe,
  input logic [7:0] rd_data,
  input logic       rx_done,
  input logic       frame_err,
  input logic       parity_err,
  input logic       overrun
);
  assert_disabled_no_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> $past(rx_en));

  assert_zero_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && cfg_width == 2'd0) |-> (rd_data[7:5] == 3'b000));

  assert_done_clear_by_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_done) |-> $past(rd_strobe));

  assert_hold_unread_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rd_strobe) |=> ($stable(rd_data) && $stable(frame_err) && $stable(parity_err)));

  assert_overrun_needs_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> ($past(rx_done) && rx_done));

  assert_overrun_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overrun) |-> $past(rd_strobe));
endmodule

bind async_frame_rx async_frame_rx_chk u_chk (.*);

// File: tb/async_frame_rx_bench.sv
`timescale 1ns/1ps
module async_frame_rx_bench;
  logic clk = 1'b0, rst_n = 1'b0, rx_line = 1'b1, os_tick = 1'b0, rx_en = 1'b0;
  logic [1:0] cfg_width = 2'd3;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, rd_strobe = 1'b0;
  logic [7:0] rd_data;
  logic rx_done, frame_err, parity_err, overrun;
  int checks = 0, fails = 0;
  logic tk = 1'b0;

  always #5 clk = ~clk;
  always @(negedge clk) begin tk <= ~tk; os_tick <= tk; end

  async_frame_rx u_async_frame_rx (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold_bit(input logic v);
    rx_line = v;
    repeat (32) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int w, input bit pe, input bit odd,
                      input bit flip, input logic stopv, input int nstop);
    logic p;
    p = odd;
    hold_bit(1'b0);
    for (int i = 0; i < w; i++) begin hold_bit(d[i]); p = p ^ d[i]; end
    if (pe) hold_bit(p ^ flip);
    hold_bit(stopv);
    rx_line = 1'b1;
    for (int i = 1; i < nstop; i++) hold_bit(1'b1);
  endtask

  task automatic do_read(input string req);
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
    chk(req, rx_done, 0);
    chk(req, overrun, 0);
  endtask

  task automatic expect_frame(input string req, input logic [7:0] d, input int fe, input int pe);
    chk(req, rx_done, 1);
    chk(req, rd_data, d);
    chk(req, frame_err, fe);
    chk(req, parity_err, pe);
    chk(req, overrun, 0);
  endtask

  function automatic logic [7:0] msk(input int w, input logic [7:0] d);
    return d & 8'((1 << w) - 1);
  endfunction

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10", {rx_done, overrun, frame_err, parity_err}, 0);
    chk("R10", rd_data, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 disabled receiver ignores line
    send(8'h5A, 8, 0, 0, 0, 1'b1, 1);
    repeat (32) @(negedge clk);
    chk("R1", rx_done, 0);
    rx_en = 1'b1;
    repeat (32) @(negedge clk);

    // R3 R4 R5 sweep over widths, parity modes and data values
    for (int w = 0; w < 4; w++) begin
      for (int pm = 0; pm < 3; pm++) begin
        cfg_width = 2'(w);
        cfg_par_en = (pm != 0);
        cfg_par_odd = (pm == 2);
        for (int k = 0; k <= 16; k++) begin
          logic [7:0] d;
          d = (k == 16) ? 8'hFF : 8'((k * 37 + pm * 5 + w) & 255);
          send(d, w + 5, pm != 0, pm == 2, 0, 1'b1, 1);
          expect_frame("R3_R4_R5", msk(w + 5, d), 0, 0);
          do_read("R8");
          repeat (8) @(negedge clk);
        end
      end
    end

    // R5 wrong parity bit, both modes
    cfg_width = 2'd3; cfg_par_en = 1'b1;
    for (int odd = 0; odd < 2; odd++) begin
      cfg_par_odd = odd[0];
      send(8'hC3, 8, 1, odd[0], 1, 1'b1, 1);
      expect_frame("R5", 8'hC3, 0, 1);
      do_read("R5");
      repeat (32) @(negedge clk);
    end
    cfg_par_en = 1'b0;

    // R6 stop bit low
    cfg_width = 2'd1;
    send(8'h2D, 6, 0, 0, 0, 1'b0, 1);
    repeat (32) @(negedge clk);
    expect_frame("R6", 8'h2D, 1, 0);
    do_read("R6");
    repeat (64) @(negedge clk);
    chk("R6", rx_done, 0);

    // R2 short low pulse rejected, then a clean frame
    cfg_width = 2'd3;
    rx_line = 1'b0;
    repeat (6) @(negedge clk);
    rx_line = 1'b1;
    repeat (64) @(negedge clk);
    chk("R2", rx_done, 0);
    send(8'h81, 8, 0, 0, 0, 1'b1, 1);
    expect_frame("R2", 8'h81, 0, 0);
    do_read("R2");
    repeat (32) @(negedge clk);

    // R7 back-to-back after one stop bit, read inside the next start bit
    fork
      begin
        send(8'hA5, 8, 0, 0, 0, 1'b1, 1);
        send(8'h3C, 8, 0, 0, 0, 1'b1, 2);
      end
      begin
        @(posedge rx_done);
        repeat (40) @(negedge clk);
        expect_frame("R7", 8'hA5, 0, 0);
        do_read("R7");
      end
    join
    expect_frame("R7", 8'h3C, 0, 0);
    do_read("R7");
    send(8'h96, 8, 0, 0, 0, 1'b1, 1);
    expect_frame("R7", 8'h96, 0, 0);
    do_read("R7");
    repeat (32) @(negedge clk);

    // R9 overrun keeps the older frame
    send(8'h11, 8, 0, 0, 0, 1'b1, 1);
    send(8'hEE, 8, 0, 0, 0, 1'b1, 1);
    chk("R9", rx_done, 1);
    chk("R9", overrun, 1);
    chk("R9", rd_data, 8'h11);
    do_read("R9");
    send(8'h42, 8, 0, 0, 0, 1'b1, 1);
    expect_frame("R9", 8'h42, 0, 0);
    do_read("R9");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule